// File: doc/BRIEF.md
# Passive-Matrix LCD Scan Timing Generator

This block produces the scan timing for a passive-matrix LCD panel. From a fast system clock it derives a divided pixel shift clock, groups shift-clock periods into lines, groups lines into frames, and drives the alternating AC-bias signal that keeps the liquid crystal from seeing a DC component. It reports the line being scanned and passes a pixel input through to the panel data lanes, masked to the lanes the chosen bus mode uses, with an optional inversion.

All counts are programmed as "value minus one": the clock divisor, the number of bus transfers per line, the number of line periods per frame and the number of lines per bias half-period. A transfer is one 4-bit nibble on a narrow or split panel and one byte on a wide, non-split panel; the transfer count is always counted the same way, only the data lanes differ. In split mode both panel halves are driven at once (upper half on bits 7:4, lower half on bits 3:0), so the line count holds half the panel height minus one. The counting fields and the bus-mode selects are captured into shadow registers while the block is disabled and again at each frame boundary, so software may rewrite them at any time without tearing a frame.

Top module: `lcd_timing_gen`

## Requirements
- R1: With clock divisor DV, shift_clk starts low after enable and toggles every DV+1 clocks, so after the n-th enabled clock edge it equals bit 0 of floor(n/(DV+1)); its period is 2*DV+2 clocks.
- R2: Each line is HX+1 transfer slots followed by one slot with line_load high, each slot one shift-clock period; line_load rises on the same edge at which shift_clk falls, first after (HX+1)*(2*DV+2) enabled clocks, then once every (HX+2)*(2*DV+2) clocks.
- R3: cur_line counts 0 up to the sampled line field NL, changes only as line_load falls, and wraps to 0 after line NL, so a frame spans NL+1 line periods in every bus mode.
- R4: first_line is high only during the line_load slot of line NL, the last line of a frame.
- R5: ac_bias starts low after enable and toggles as line_load falls after every DF+1 completed lines; a field of 0 toggles it on every line.
- R6: While vid_en is low, all counters are cleared: one clock after vid_en is seen low, shift_clk, line_load, first_line, ac_bias and cur_line are 0, and pix_out is 0 at once.
- R7: clk_div, h_xfers, n_lines, df_div, split_sel and wide_sel are captured while vid_en is low and at the end of the last line of a frame; a change made mid-frame affects timing and lanes only from the next frame.
- R8: Lane use by sampled mode: split_sel=1 (priority) drives all 8 bits, upper half-panel on [7:4] and lower on [3:0]; split_sel=0 with wide_sel=1 drives all 8 bits as one byte; both 0 drives only [3:0] with [7:4] held at 0.
- R9: With invert high, every active lane bit of pix_out is the complement of pix_in; inactive lanes stay 0. invert acts at once, not at frame boundaries.
- R10: With disp_on low, pix_out is 0 and panel_on is low while the scan timing keeps running; panel_on is high only when vid_en and disp_on are both high.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_en | input | 1 | Scan enable; low holds all counters cleared |
| disp_on | input | 1 | Panel display-on control |
| invert | input | 1 | Complement active pixel lanes |
| clk_div | input | 5 | Shift-clock divisor minus one (half period in clocks minus one) |
| h_xfers | input | 9 | Bus transfers per line minus one |
| n_lines | input | 10 | Line periods per frame minus one |
| df_div | input | 8 | Lines per AC-bias half period minus one |
| split_sel | input | 1 | Dual-half panel, two 4-bit lanes |
| wide_sel | input | 1 | 8-bit bus on a non-split panel |
| pix_in | input | 8 | Pixel data to pass to the panel |
| shift_clk | output | 1 | Pixel shift clock |
| line_load | output | 1 | Line-load pulse, one shift period per line |
| first_line | output | 1 | Frame marker during the last line-load of a frame |
| ac_bias | output | 1 | AC-bias toggle signal |
| panel_on | output | 1 | Display-on to the panel |
| cur_line | output | 10 | Line currently being scanned |
| pix_out | output | 8 | Panel data lanes |

## Verification
The bench targets the spot where a field written mid-frame must not disturb the frame in progress: a design that sampled live values would move the next line-load pulse early and shift every later event, which the scoreboard catches by timestamp. It runs a single-transfer line with a zero clock divisor and a zero bias field, where an off-by-one in the slot count or the bias counter shows up as a wrong pulse time or a bias value that fails to alternate. It disables the scan in the middle of a line while the bias output is high, so that a counter that is not cleared leaves a stale bias or line number, and it checks the lane mask in all three bus modes, where a wrong split priority or a missing nibble mask leaks data onto unused lanes.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

    parameter int DIV_W  = 5;
    parameter int HCNT_W = 9;
    parameter int LCNT_W = 10;
    parameter int DF_W   = 8;
    parameter int LANE_W = 4;

    localparam int BUS_W = 2 * LANE_W;
    localparam int XCNT_W = HCNT_W + 1;

    typedef enum logic [1:0] {
        BUS_NARROW = 2'd0,
        BUS_WIDE   = 2'd1,
        BUS_SPLIT  = 2'd2
    } bus_mode_e;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [HCNT_W-1:0] hval;
        logic [LCNT_W-1:0] lval;
        logic [DF_W-1:0]   dfval;
        logic              split;
        logic              wide;
    } scan_cfg_t;

    function automatic bus_mode_e pick_mode(input logic split, input logic wide);
        if (split)
            return BUS_SPLIT;
        else if (wide)
            return BUS_WIDE;
        return BUS_NARROW;
    endfunction

    function automatic logic [BUS_W-1:0] lane_mask(input bus_mode_e mode);
        case (mode)
            BUS_NARROW: return {{LANE_W{1'b0}}, {LANE_W{1'b1}}};
            default:    return {BUS_W{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/lcd_shift_div.sv
module lcd_shift_div
    import lcd_timing_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             slot_end
);

    logic [DIV_W-1:0] cnt;
    logic             half_end;

    assign half_end = (cnt == div);
    // a slot closes on the half period that ends with the clock high
    assign slot_end = half_end & sclk;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (half_end) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_scan_ctr.sv
module lcd_scan_ctr
    import lcd_timing_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              slot_end,
    input  logic [HCNT_W-1:0] hval,
    input  logic [LCNT_W-1:0] lval,
    output logic              line_load,
    output logic              line_end,
    output logic              frame_end,
    output logic              first_line,
    output logic [LCNT_W-1:0] cur_line
);

    logic [XCNT_W-1:0] xcnt;
    logic [XCNT_W-1:0] xlast;
    logic [LCNT_W-1:0] ycnt;
    logic              last_row;

    // slots 0..hval carry data, slot hval+1 is the load slot
    assign xlast      = {1'b0, hval} + 1'b1;
    assign line_load  = (xcnt == xlast);
    assign last_row   = (ycnt == lval);
    assign line_end   = slot_end & line_load;
    assign frame_end  = line_end & last_row;
    assign first_line = line_load & last_row;
    assign cur_line   = ycnt;

    always_ff @(posedge clk) begin
        if (clr) begin
            xcnt <= '0;
            ycnt <= '0;
        end else if (slot_end) begin
            if (line_load) begin
                xcnt <= '0;
                ycnt <= last_row ? '0 : ycnt + 1'b1;
            end else begin
                xcnt <= xcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcd_bias_gen.sv
module lcd_bias_gen
    import lcd_timing_pkg::*;
(
    input  logic            clk,
    input  logic            clr,
    input  logic            line_end,
    input  logic [DF_W-1:0] dfval,
    output logic            bias
);

    logic [DF_W-1:0] lines_seen;

    always_ff @(posedge clk) begin
        if (clr) begin
            lines_seen <= '0;
            bias       <= 1'b0;
        end else if (line_end) begin
            if (lines_seen == dfval) begin
                lines_seen <= '0;
                bias       <= ~bias;
            end else begin
                lines_seen <= lines_seen + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcd_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vid_en,
    input  logic              disp_on,
    input  logic              invert,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [HCNT_W-1:0] h_xfers,
    input  logic [LCNT_W-1:0] n_lines,
    input  logic [DF_W-1:0]   df_div,
    input  logic              split_sel,
    input  logic              wide_sel,
    input  logic [BUS_W-1:0]  pix_in,
    output logic              shift_clk,
    output logic              line_load,
    output logic              first_line,
    output logic              ac_bias,
    output logic              panel_on,
    output logic [LCNT_W-1:0] cur_line,
    output logic [BUS_W-1:0]  pix_out
);

    scan_cfg_t cfg_in;
    scan_cfg_t cfg_q;
    logic      clr;
    logic      slot_end;
    logic      line_end;
    logic      frame_end;
    bus_mode_e mode;

    assign clr = rst | ~vid_en;

    assign cfg_in = '{div:   clk_div,
                      hval:  h_xfers,
                      lval:  n_lines,
                      dfval: df_div,
                      split: split_sel,
                      wide:  wide_sel};

    // shadow copy: follows the inputs while idle, reloads only between frames
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (!vid_en || frame_end)
            cfg_q <= cfg_in;
    end

    lcd_shift_div u_div (
        .clk      (clk),
        .clr      (clr),
        .div      (cfg_q.div),
        .sclk     (shift_clk),
        .slot_end (slot_end)
    );

    lcd_scan_ctr u_scan (
        .clk        (clk),
        .clr        (clr),
        .slot_end   (slot_end),
        .hval       (cfg_q.hval),
        .lval       (cfg_q.lval),
        .line_load  (line_load),
        .line_end   (line_end),
        .frame_end  (frame_end),
        .first_line (first_line),
        .cur_line   (cur_line)
    );

    lcd_bias_gen u_bias (
        .clk      (clk),
        .clr      (clr),
        .line_end (line_end),
        .dfval    (cfg_q.dfval),
        .bias     (ac_bias)
    );

    assign mode     = pick_mode(cfg_q.split, cfg_q.wide);
    assign panel_on = vid_en & disp_on;

    always_comb begin
        if (vid_en && disp_on)
            pix_out = (pix_in ^ {BUS_W{invert}}) & lane_mask(mode);
        else
            pix_out = '0;
    end

endmodule

// File: rtl/lcd_timing_chk.sv
module lcd_timing_chk
    import lcd_timing_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              vid_en,
    input logic              shift_clk,
    input logic              line_load,
    input logic              first_line,
    input logic              ac_bias,
    input logic [LCNT_W-1:0] cur_line,
    input logic [LCNT_W-1:0] lval_q
);

    // R6: a disabled cycle leaves every timing output cleared
    a_r6_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !vid_en |=> (!shift_clk && !line_load && !first_line && !ac_bias && cur_line == '0));

    // R2: the load slot opens exactly as a shift period closes
    a_r2_load_on_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(line_load) |-> $fell(shift_clk));

    // R4: the frame marker never appears outside a load slot
    a_r4_first_in_load: assert property (@(posedge clk) disable iff (rst)
        first_line |-> line_load);

    // R5: the bias signal moves only when a line finishes
    a_r5_bias_at_line_end: assert property (@(posedge clk) disable iff (rst)
        (vid_en && $past(vid_en) && !$stable(ac_bias)) |-> $fell(line_load));

    // R3: the line number stays within the sampled frame height
    a_r3_line_bounded: assert property (@(posedge clk) disable iff (rst)
        cur_line <= lval_q);

    // R3: the line number advances only when a line finishes
    a_r3_line_steps: assert property (@(posedge clk) disable iff (rst)
        (vid_en && $past(vid_en) && !$stable(cur_line)) |-> $fell(line_load));

endmodule

bind lcd_timing_gen lcd_timing_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .vid_en     (vid_en),
    .shift_clk  (shift_clk),
    .line_load  (line_load),
    .first_line (first_line),
    .ac_bias    (ac_bias),
    .cur_line   (cur_line),
    .lval_q     (cfg_q.lval)
);

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;
    import lcd_timing_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              vid_en, disp_on, invert, split_sel, wide_sel;
    logic [DIV_W-1:0]  clk_div;
    logic [HCNT_W-1:0] h_xfers;
    logic [LCNT_W-1:0] n_lines;
    logic [DF_W-1:0]   df_div;
    logic [BUS_W-1:0]  pix_in;
    logic              shift_clk, line_load, first_line, ac_bias, panel_on;
    logic [LCNT_W-1:0] cur_line;
    logic [BUS_W-1:0]  pix_out;

    lcd_timing_gen i_lcd_timing_gen (.*);

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    typedef struct {
        int t;
        int line;
        bit first;
        bit df;
    } ev_t;

    ev_t sb[$];
    ev_t mon_e;
    bit  ll_prev = 1'b0;
    int  g_base;
    int  g_dfc;
    bit  g_dfv;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // enabled-clock counter: n after the n-th edge that saw vid_en high
    always @(posedge clk) cyc <= vid_en ? cyc + 1 : 0;

    task automatic gen_reset();
        g_base = 0;
        g_dfc  = 0;
        g_dfv  = 1'b0;
    endtask

    // driver side: expected line-load events for whole frames
    task automatic push_frames(input int dv, input int hx, input int nl, input int df, input int nfr);
        int s = 2 * (dv + 1);
        int p = (hx + 2) * s;
        for (int f = 0; f < nfr; f++) begin
            for (int y = 0; y <= nl; y++) begin
                ev_t e;
                e.t = g_base + y * p + (hx + 1) * s;
                e.line = y;
                e.first = (y == nl);
                e.df = g_dfv;
                sb.push_back(e);
                if (g_dfc == df) begin
                    g_dfc = 0;
                    g_dfv = ~g_dfv;
                end else begin
                    g_dfc++;
                end
            end
            g_base += (nl + 1) * p;
        end
    endtask

    // monitor side: pops one expected event per line-load pulse
    always @(negedge clk) begin
        if (line_load && !ll_prev) begin
            if (sb.size() == 0) begin
                check("R2 unexpected line_load", 1, 0);
            end else begin
                mon_e = sb.pop_front();
                check("R2 line_load start cycle", cyc, mon_e.t);
                check("R3 cur_line at load", int'(cur_line), mon_e.line);
                check("R4 first_line at load", int'(first_line), int'(mon_e.first));
                check("R5 ac_bias at load", int'(ac_bias), int'(mon_e.df));
            end
        end
        ll_prev = line_load;
    end

    task automatic set_cfg(input int dv, input int hx, input int nl, input int df,
                           input bit sp, input bit wd);
        clk_div   = DIV_W'(dv);
        h_xfers   = HCNT_W'(hx);
        n_lines   = LCNT_W'(nl);
        df_div    = DF_W'(df);
        split_sel = sp;
        wide_sel  = wd;
    endtask

    task automatic wait_cyc(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic check_sclk(input int dv, input int ncyc);
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            check("R1 shift_clk phase", int'(shift_clk), (cyc / (dv + 1)) % 2);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        vid_en = 1'b0; disp_on = 1'b0; invert = 1'b0;
        pix_in = '0;
        set_cfg(0, 0, 0, 0, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check("R11 shift_clk", int'(shift_clk), 0);
        check("R11 line_load", int'(line_load), 0);
        check("R11 first_line", int'(first_line), 0);
        check("R11 ac_bias", int'(ac_bias), 0);
        check("R11 cur_line", int'(cur_line), 0);
        check("R11 panel_on", int'(panel_on), 0);

        // R6: disabled blocks data
        disp_on = 1'b1;
        pix_in  = 8'hFF;
        #1 check("R6 pix_out while disabled", int'(pix_out), 0);

        // run 1: narrow bus, divisor 1, 4 transfers, 4 lines, bias every 3 lines
        set_cfg(1, 3, 3, 2, 1'b0, 1'b0);
        @(negedge clk);
        gen_reset();
        push_frames(1, 3, 3, 2, 2);
        vid_en = 1'b1;
        check_sclk(1, 10);
        pix_in = 8'hA5; invert = 1'b0;
        #1 check("R8 narrow lane mask", int'(pix_out), 8'h05);
        invert = 1'b1;
        #1 check("R9 invert narrow", int'(pix_out), 8'h0A);
        check("R10 panel_on high", int'(panel_on), 1);
        disp_on = 1'b0;
        #1 check("R10 pix_out blanked", int'(pix_out), 0);
        check("R10 panel_on low", int'(panel_on), 0);
        disp_on = 1'b1; invert = 1'b0;
        wait (sb.size() == 0);
        vid_en = 1'b0;
        @(negedge clk);
        check("R6 shift_clk cleared", int'(shift_clk), 0);
        check("R6 line_load cleared", int'(line_load), 0);

        // run 2: mid-frame rewrite, takes effect at frame boundary (R7)
        set_cfg(1, 3, 3, 2, 1'b0, 1'b0);
        @(negedge clk);
        gen_reset();
        push_frames(1, 3, 3, 2, 1);
        push_frames(0, 5, 1, 2, 3);
        vid_en = 1'b1;
        wait_cyc(30);
        set_cfg(0, 5, 1, 2, 1'b1, 1'b0);
        wait_cyc(40);
        pix_in = 8'hA5;
        #1 check("R7 lane mode held mid-frame", int'(pix_out), 8'h05);
        wait_cyc(90);
        #1 check("R8 split drives both lanes", int'(pix_out), 8'hA5);
        wait (sb.size() == 0);
        for (int i = 0; i < 40; i++) begin
            if (shift_clk && !line_load) break;
            @(negedge clk);
        end
        check("R5 ac_bias high before disable", int'(ac_bias), 1);
        vid_en = 1'b0;
        #1 check("R6 pix_out immediate", int'(pix_out), 0);
        @(negedge clk);
        check("R6 ac_bias cleared", int'(ac_bias), 0);
        check("R6 shift_clk cleared mid-line", int'(shift_clk), 0);
        check("R6 cur_line cleared", int'(cur_line), 0);

        // run 3: wide bus, minimum divisor and line length, bias every line
        set_cfg(0, 0, 2, 0, 1'b0, 1'b1);
        pix_in = 8'h3C; invert = 1'b1;
        @(negedge clk);
        gen_reset();
        push_frames(0, 0, 2, 0, 2);
        vid_en = 1'b1;
        #1 check("R8 wide byte inverted", int'(pix_out), 8'hC3);
        check_sclk(0, 6);
        wait (sb.size() == 0);
        vid_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R6 line_load quiet after disable", int'(line_load), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule